// File: doc/BRIEF.md
# OFDM Input Rate Controller

This block sits at the input of a receive chain whose transform always works on symbols of the largest size, 2048 points. An upstream source may deliver samples at the native rate of a narrower channel bandwidth. In that case each native symbol holds fewer samples, but it must still take up one full maximum-size symbol period on the processing clock. The controller drives a `ready` handshake that lets the source deliver one symbol's worth of samples and then holds it off for the rest of the period. It forwards every accepted sample, with its valid flag, to the downstream repeater.

An elaboration parameter selects one of two variants. The full-rate variant applies no throttling and keeps `ready` high at all times. The matched-rate variant runs a repeating high/low pattern with one period per OFDM symbol. The period length follows the cyclic prefix of that symbol. The length of the high phase comes from the native transform and prefix lengths of the selected bandwidth. A second parameter chooses how the high phase is sized: for a source that streams without gaps, or for a source that delivers in bursts. The bandwidth code and the prefix type are captured when a subframe begins and are held until it ends. A synchronous clear returns the block to idle.

Top module: `ofdm_rate_throttle`

## Requirements
- R1: After reset or after a clear, the block is idle. `ready` is 1 and `out_valid` is 0, and it stays idle until the first sample with `in_valid` high arrives. That sample is accepted and becomes sample 0 of the first symbol of a new subframe.
- R2: `bw_code` values 0, 1, 2, 3, 4 and 5 select 6, 15, 25, 50, 75 and 100 resource blocks. The native transform length is 2048 >> s, where s = 4 − code for codes 0 to 3 and s = 0 for codes 4 and 5. Codes 6 and 7 behave as code 5.
- R3: With `ext_cp` = 0 (normal prefix), a slot holds 7 symbols. The prefix is 160 full-rate samples on symbol 0 of each slot and 144 on the others. With `ext_cp` = 1, a slot holds 6 symbols, each with a 512-sample prefix. A subframe is 2 slots. The native prefix is the full-rate prefix >> s.
- R4: Every symbol in the matched-rate variant takes exactly 2048 + (full-rate prefix) clock cycles.
- R5: For the gap-free sizing, the acceptance window is open for the first N + C cycles of each symbol, where N and C are the native transform and prefix lengths. For example, code 0 with a normal prefix on symbol 0 gives 138 open and 2070 closed cycles.
- R6: For the burst sizing, the window is open for (N + C − 1)·2^s + 1 cycles. For example, code 0 with a normal prefix on symbol 0 gives 2193 open and 15 closed cycles.
- R7: `ready` announces the window one cycle ahead. A sample offered while `ready` was low in the previous cycle is dropped and produces no output.
- R8: An accepted sample appears on `out_re`/`out_im` with `out_valid` high exactly one cycle later.
- R9: `bw_code` and `ext_cp` are captured only when a subframe starts. Changes in the middle of a subframe do not alter the pattern until the next subframe boundary.
- R10: In the full-rate variant `ready` is always 1. Every sample with `in_valid` high is forwarded one cycle later.
- R11: A clear in the middle of a stream drops the sample offered in that cycle and abandons the current subframe. The next valid sample starts a fresh subframe with newly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous return to idle |
| bw_code | input | 3 | Bandwidth selector, captured per subframe |
| ext_cp | input | 1 | 1 selects the extended prefix, captured per subframe |
| in_valid | input | 1 | Upstream sample present |
| in_re | input | DW | Upstream sample, real part |
| in_im | input | DW | Upstream sample, imaginary part |
| ready | output | 1 | Window is open in the next cycle |
| out_valid | output | 1 | Forwarded sample present |
| out_re | output | DW | Forwarded sample, real part |
| out_im | output | DW | Forwarded sample, imaginary part |

## Verification
The embedded properties assume that the source honours the one-cycle lead of `ready`. They also assume that `clear` is a single-cycle request and that the bandwidth and prefix inputs settle before a subframe boundary. The stimulus changes these settings only at arbitrary cycles well before a boundary, pulses `clear` for exactly one cycle, and includes both gap-free and randomly gapped valid streams. Under these conditions the bench's cycle model predicts every open and closed cycle of `ready` across whole subframes for both sizings, including the ignored mid-subframe setting changes and the restart after a clear.

// File: rtl/orc_pkg.sv
package orc_pkg;
   localparam int unsigned BW_CODE_W = 3;

   typedef struct packed {
      logic [BW_CODE_W-1:0] bw;
      logic                 ext;
   } orc_cfg_t;
endpackage

// File: rtl/orc_sym_timing.sv
module orc_sym_timing #(
   parameter int LOG2_NMAX = 11,
   parameter int MAX_SHIFT = 4,
   parameter int CP_FIRST  = 160,
   parameter int CP_REST   = 144,
   parameter int CP_EXT    = 512,
   parameter bit BURST     = 1'b0,
   parameter int CNT_W     = 12
) (
   input  orc_pkg::orc_cfg_t cfg,
   input  logic              first_sym,
   output logic [CNT_W-1:0]  period_len,
   output logic [CNT_W-1:0]  high_len
);
   localparam int NMAX = 1 << LOG2_NMAX;
   localparam int SH_W = $clog2(MAX_SHIFT + 1);

   logic [SH_W-1:0]  sh;
   logic [CNT_W-1:0] cp_full;
   logic [CNT_W-1:0] n_nat;
   logic [CNT_W-1:0] cp_nat;

   always_comb begin
      if (int'(cfg.bw) < MAX_SHIFT) sh = SH_W'(MAX_SHIFT - int'(cfg.bw));
      else                          sh = '0;
      if (cfg.ext)        cp_full = CNT_W'(CP_EXT);
      else if (first_sym) cp_full = CNT_W'(CP_FIRST);
      else                cp_full = CNT_W'(CP_REST);
      period_len = CNT_W'(NMAX) + cp_full;
      n_nat      = CNT_W'(NMAX) >> sh;
      cp_nat     = cp_full >> sh;
   end

   generate
      if (BURST) begin : g_burst
         assign high_len = ((n_nat + cp_nat - CNT_W'(1)) << sh) + CNT_W'(1);
      end else begin : g_stream
         assign high_len = n_nat + cp_nat;
      end
   endgenerate
endmodule

// File: rtl/orc_pattern.sv
module orc_pattern #(
   parameter int LOG2_NMAX    = 11,
   parameter int MAX_SHIFT    = 4,
   parameter int CP_FIRST     = 160,
   parameter int CP_REST      = 144,
   parameter int CP_EXT       = 512,
   parameter bit BURST        = 1'b0,
   parameter int NUM_SYM_NORM = 7,
   parameter int NUM_SYM_EXT  = 6,
   parameter int SLOTS        = 2,
   parameter int CNT_W        = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              in_valid,
   input  orc_pkg::orc_cfg_t cfg_in,
   output logic              win,
   output logic              ready
);
   localparam int SYM_W  = $clog2(NUM_SYM_NORM);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam logic [SYM_W-1:0]  LAST_NORM = SYM_W'(NUM_SYM_NORM - 1);
   localparam logic [SYM_W-1:0]  LAST_EXT  = SYM_W'(NUM_SYM_EXT - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic              running;
   logic [CNT_W-1:0]  cnt;
   logic [SYM_W-1:0]  sym_idx;
   logic [SLOT_W-1:0] slot_idx;
   orc_pkg::orc_cfg_t cfg_q;
   logic [CNT_W-1:0]  period_len;
   logic [CNT_W-1:0]  high_len;
   logic              wrap;
   logic              last_sym;
   logic              sf_end;

   orc_sym_timing #(
      .LOG2_NMAX(LOG2_NMAX), .MAX_SHIFT(MAX_SHIFT), .CP_FIRST(CP_FIRST),
      .CP_REST(CP_REST), .CP_EXT(CP_EXT), .BURST(BURST), .CNT_W(CNT_W)
   ) u_timing (
      .cfg       (cfg_q),
      .first_sym (sym_idx == '0),
      .period_len(period_len),
      .high_len  (high_len)
   );

   assign wrap     = running && (cnt == period_len - CNT_W'(1));
   assign last_sym = sym_idx == (cfg_q.ext ? LAST_EXT : LAST_NORM);
   assign sf_end   = wrap && last_sym && (slot_idx == LAST_SLOT);
   assign win      = !running || (cnt < high_len);
   assign ready    = !running || wrap || ((cnt + CNT_W'(1)) < high_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         cnt      <= '0;
         sym_idx  <= '0;
         slot_idx <= '0;
         cfg_q    <= '0;
      end else if (clear) begin
         running  <= 1'b0;
         cnt      <= '0;
         sym_idx  <= '0;
         slot_idx <= '0;
      end else if (!running) begin
         if (in_valid) begin
            running  <= 1'b1;
            cnt      <= CNT_W'(1);
            sym_idx  <= '0;
            slot_idx <= '0;
            cfg_q    <= cfg_in;
         end
      end else if (wrap) begin
         cnt <= '0;
         if (last_sym) begin
            sym_idx <= '0;
            if (slot_idx == LAST_SLOT) begin
               slot_idx <= '0;
               cfg_q    <= cfg_in;
            end else begin
               slot_idx <= slot_idx + SLOT_W'(1);
            end
         end else begin
            sym_idx <= sym_idx + SYM_W'(1);
         end
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   // R4
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> cnt < period_len);

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !sf_end && !clear) |=> $stable(cfg_q));

   // R5
   wrap_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !clear) |=> ready);
endmodule

// File: rtl/orc_gate.sv
module orc_gate #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 in_valid,
   input  logic                 take,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im
);
   logic accept;
   assign accept = in_valid && take && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            out_re <= in_re;
            out_im <= in_im;
         end
      end
   end
endmodule

// File: rtl/ofdm_rate_throttle.sv
module ofdm_rate_throttle #(
   parameter int DW           = 16,
   parameter bit MATCHED      = 1'b1,
   parameter bit BURST        = 1'b0,
   parameter int LOG2_NMAX    = 11,
   parameter int MAX_SHIFT    = 4,
   parameter int CP_FIRST     = 160,
   parameter int CP_REST      = 144,
   parameter int CP_EXT       = 512,
   parameter int NUM_SYM_NORM = 7,
   parameter int NUM_SYM_EXT  = 6,
   parameter int SLOTS        = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic [2:0]           bw_code,
   input  logic                 ext_cp,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 ready,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im
);
   localparam int NMAX  = 1 << LOG2_NMAX;
   localparam int CNT_W = $clog2(NMAX + CP_EXT + 1);
   localparam int GRAIN = 1 << MAX_SHIFT;

   generate
      if ((CP_FIRST % GRAIN) != 0 || (CP_REST % GRAIN) != 0 || (CP_EXT % GRAIN) != 0) begin : g_bad_cp
         $error("prefix lengths must divide evenly at the narrowest bandwidth");
      end
      if (CP_EXT < CP_FIRST || CP_FIRST < CP_REST) begin : g_bad_order
         $error("prefix lengths out of order");
      end
      if (LOG2_NMAX <= MAX_SHIFT || MAX_SHIFT > 7) begin : g_bad_shift
         $error("shift range does not fit the transform size");
      end
      if (SLOTS < 2 || NUM_SYM_EXT > NUM_SYM_NORM || NUM_SYM_EXT < 1) begin : g_bad_frame
         $error("slot structure out of range");
      end
   endgenerate

   logic take;

   generate
      if (MATCHED) begin : g_matched
         orc_pkg::orc_cfg_t cfg_in;
         assign cfg_in.bw  = bw_code;
         assign cfg_in.ext = ext_cp;

         orc_pattern #(
            .LOG2_NMAX(LOG2_NMAX), .MAX_SHIFT(MAX_SHIFT), .CP_FIRST(CP_FIRST),
            .CP_REST(CP_REST), .CP_EXT(CP_EXT), .BURST(BURST),
            .NUM_SYM_NORM(NUM_SYM_NORM), .NUM_SYM_EXT(NUM_SYM_EXT),
            .SLOTS(SLOTS), .CNT_W(CNT_W)
         ) u_pattern (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .in_valid(in_valid),
            .cfg_in  (cfg_in),
            .win     (take),
            .ready   (ready)
         );

         // R7
         reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ready && !clear) |-> ##2 !out_valid);
      end else begin : g_full
         logic unused_cfg;
         assign unused_cfg = ^{bw_code, ext_cp};
         assign take  = 1'b1;
         assign ready = 1'b1;

         // R10
         forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !clear) |=> out_valid);
      end
   endgenerate

   orc_gate #(.DW(DW)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .in_valid (in_valid),
      .take     (take),
      .in_re    (in_re),
      .in_im    (in_im),
      .out_valid(out_valid),
      .out_re   (out_re),
      .out_im   (out_im)
   );
endmodule

// File: tb/sim_ofdm_rate_throttle.sv
module sim_ofdm_rate_throttle;
   localparam int DW = 16;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 clr = 1'b0;
   logic [2:0]           bw = '0;
   logic                 ext = 1'b0;
   logic                 vld = 1'b0;
   logic signed [DW-1:0] dre = '0;
   logic signed [DW-1:0] dim = '0;
   logic                 rdy [3];
   logic                 ov  [3];
   logic signed [DW-1:0] ore [3];
   logic signed [DW-1:0] oim [3];

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ofdm_rate_throttle #(.DW(DW), .MATCHED(1'b1), .BURST(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .clear(clr), .bw_code(bw), .ext_cp(ext),
      .in_valid(vld), .in_re(dre), .in_im(dim), .ready(rdy[0]),
      .out_valid(ov[0]), .out_re(ore[0]), .out_im(oim[0]));
   ofdm_rate_throttle #(.DW(DW), .MATCHED(1'b1), .BURST(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .clear(clr), .bw_code(bw), .ext_cp(ext),
      .in_valid(vld), .in_re(dre), .in_im(dim), .ready(rdy[1]),
      .out_valid(ov[1]), .out_re(ore[1]), .out_im(oim[1]));
   ofdm_rate_throttle #(.DW(DW), .MATCHED(1'b0)) u2 (
      .clk(clk), .rst_n(rst_n), .clear(clr), .bw_code(bw), .ext_cp(ext),
      .in_valid(vld), .in_re(dre), .in_im(dim), .ready(rdy[2]),
      .out_valid(ov[2]), .out_re(ore[2]), .out_im(oim[2]));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         if (n_bad < 20) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R3: full-rate prefix per symbol
   function automatic int cp_of(bit e, bit first);
      return e ? 512 : (first ? 160 : 144);
   endfunction
   // R2: bandwidth code to shift
   function automatic int sh_of(int b);
      return (b < 4) ? 4 - b : 0;
   endfunction
   // R5 and R6: open-window length
   function automatic int high_of(int b, bit e, bit first, bit burst);
      int s = sh_of(b);
      int n = 2048 >> s;
      int c = cp_of(e, first) >> s;
      return burst ? (((n + c - 1) << s) + 1) : (n + c);
   endfunction

   bit m_run [2];
   int m_cnt [2];
   int m_sym [2];
   int m_slot[2];
   int m_bw  [2];
   bit m_ext [2];
   bit e_ov  [3];
   logic signed [DW-1:0] e_re = '0;
   logic signed [DW-1:0] e_im = '0;

   task automatic step();
      int cur_bw = (int'(bw) > 5) ? 5 : int'(bw);  // R2: codes 6 and 7 act as 5
      for (int i = 0; i < 2; i++) begin
         bit first = (m_sym[i] == 0);
         int h = high_of(m_bw[i], m_ext[i], first, bit'(i));
         int p = 2048 + cp_of(m_ext[i], first);  // R4
         bit win = !m_run[i] || (m_cnt[i] < h);
         bit acc = vld && win && !clr;
         bit n_run = m_run[i];
         int n_cnt = m_cnt[i];
         int n_sym = m_sym[i];
         int n_slot = m_slot[i];
         int n_bw = m_bw[i];
         bit n_ext = m_ext[i];
         bit exp_rdy;
         if (clr) begin  // R11
            n_run = 1'b0; n_cnt = 0; n_sym = 0; n_slot = 0;
         end else if (!m_run[i]) begin  // R1
            if (vld) begin
               n_run = 1'b1; n_cnt = 1; n_sym = 0; n_slot = 0;
               n_bw = cur_bw; n_ext = ext;
            end
         end else if (m_cnt[i] == p - 1) begin
            n_cnt = 0;
            if (m_sym[i] == (m_ext[i] ? 5 : 6)) begin  // R3
               n_sym = 0;
               if (m_slot[i] == 1) begin  // R9: capture only here
                  n_slot = 0; n_bw = cur_bw; n_ext = ext;
               end else begin
                  n_slot = 1;
               end
            end else begin
               n_sym = m_sym[i] + 1;
            end
         end else begin
            n_cnt = m_cnt[i] + 1;
         end
         exp_rdy = !n_run || (n_cnt < high_of(n_bw, n_ext, n_sym == 0, bit'(i)));
         if (!clr) check(rdy[i] == exp_rdy, (i == 0) ? "R5 ready" : "R6 ready",
                         int'(rdy[i]), int'(exp_rdy));
         check(ov[i] == e_ov[i], "R7 out_valid", int'(ov[i]), int'(e_ov[i]));
         if (e_ov[i]) check(ore[i] == e_re && oim[i] == e_im, "R8 data",
                            int'(ore[i]), int'(e_re));
         e_ov[i] = acc;
         m_run[i] = n_run; m_cnt[i] = n_cnt; m_sym[i] = n_sym;
         m_slot[i] = n_slot; m_bw[i] = n_bw; m_ext[i] = n_ext;
      end
      check(rdy[2] == 1'b1, "R10 ready", int'(rdy[2]), 1);
      check(ov[2] == e_ov[2], "R10 out_valid", int'(ov[2]), int'(e_ov[2]));
      if (e_ov[2]) check(ore[2] == e_re && oim[2] == e_im, "R10 data",
                         int'(ore[2]), int'(e_re));
      e_ov[2] = vld && !clr;
      e_re = dre;
      e_im = dim;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) e_ov[i] = 1'b0;
      for (int i = 0; i < 2; i++) begin
         m_run[i] = 1'b0; m_cnt[i] = 0; m_sym[i] = 0; m_slot[i] = 0;
         m_bw[i] = 0; m_ext[i] = 1'b0;
      end
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: state right after reset
      for (int i = 0; i < 3; i++) begin
         check(rdy[i] == 1'b1, "R1 ready after reset", int'(rdy[i]), 1);
         check(ov[i] == 1'b0, "R1 out_valid after reset", int'(ov[i]), 0);
      end
      for (int c = 0; c < 140000; c++) begin
         @(negedge clk);
         clr = 1'b0;
         dre = DW'($urandom);
         dim = DW'($urandom);
         if (c < 20) vld = 1'b0;                         // R1: idle hold
         else if (c < 75000) vld = 1'b1;                 // gap-free stream
         else if (c == 75000) begin vld = 1'b1; clr = 1'b1; end  // R11
         else if (c < 75050) vld = 1'b0;
         else vld = ($urandom % 4) != 0;                 // gapped stream
         if (c == 0) begin bw = 3'd0; ext = 1'b0; end
         if (c == 10000) bw = 3'd3;                      // R9: mid-subframe change
         if (c == 40000) begin bw = 3'd2; ext = 1'b1; end
         if (c == 75000) begin bw = 3'd7; ext = 1'b0; end  // R2: code above 5
         if (c == 105000) bw = 3'd1;
         step();
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule